// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

A small clocked storage element whose contents can be replaced from a parallel bus, moved one place toward the high end, moved one place toward the low end, or left alone. A two-bit mode code chooses the action, and the register carries it out on the rising clock edge. Each shift direction has its own serial input. The serial input for a right shift fills the vacated low bit. The serial input for a left shift fills the vacated high bit.

An active-low clear empties the register at once, without waiting for a clock edge. While it is held low, the clock has no effect. The block is used as a building element for serialisers, deserialisers and simple data-path staging. The width is a parameter that defaults to four.

The mode code acts as the register's state selector. It names four actions:

- HOLD (00) keeps the current value.
- SHR (01) moves the value toward bit 3.
- SHL (10) moves the value toward bit 0.
- LOAD (11) takes in the parallel bus.

The clear input moves the register into the cleared condition from any action. The register leaves the cleared condition at the first rising edge after clear is released.

Top module: `usr4_shift`

## Requirements
- R1: With mode = 11 (LOAD), a rising edge copies par_d into q, so q[i] = par_d[i].
- R2: With mode = 01 (SHR), a rising edge makes q[0] = ser_r and q[i] = the old q[i-1] for i >= 1.
- R3: With mode = 10 (SHL), a rising edge makes q[3] = ser_l and q[i] = the old q[i+1] for i <= 2.
- R4: With mode = 00 (HOLD), a rising edge leaves q unchanged, whatever the values of par_d, ser_r and ser_l.
- R5: Driving clr_n low forces q to 0000 at once, with no clock edge needed.
- R6: While clr_n is low, rising edges leave q at 0000 in every mode, including LOAD.
- R7: q changes only at a rising clock edge, apart from the clear. Mode and data changes between edges do not move q.
- R8: A shift uses only the serial input for its own direction. ser_l has no effect in SHR, and ser_r has no effect in SHL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; actions happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Action code: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r | input | 1 | Serial bit entering q[0] on a right shift |
| ser_l | input | 1 | Serial bit entering q[3] on a left shift |
| par_d | input | 4 | Parallel data for load |
| q | output | 4 | Register contents |

## Verification
The bench targets the serial entry points. It drives the unused serial input to the opposite value during a shift, so a design that mixed up the two serial inputs, or the shift direction, would produce a different pattern at q.

HOLD cycles run with every data input set against the held value, which exposes a hold that leaks par_d or a serial bit. For the clear, the bench first drops clr_n between edges and samples q before the next edge, which catches a clear that only works synchronously. It then keeps clr_n low across an edge in LOAD mode, which catches a load that takes priority over the clear. Between edges, q is also sampled after the inputs change, to catch any path that bypasses the register.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [1:0] {
        M_HOLD = 2'b00,
        M_SHR  = 2'b01,
        M_SHL  = 2'b10,
        M_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    output usr_mode_e  mode
);
    always_comb begin
        unique case (sel)
            2'b00:   mode = M_HOLD;
            2'b01:   mode = M_SHR;
            2'b10:   mode = M_SHL;
            default: mode = M_LOAD;
        endcase
    end
endmodule

// File: rtl/usr_next.sv
module usr_next
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  usr_mode_e          mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   par_d,
    input  logic               ser_r,
    input  logic               ser_l,
    output logic [WIDTH-1:0]   nxt
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] from_low;   // value each bit takes on a right shift
    logic [WIDTH-1:0] from_high;  // value each bit takes on a left shift

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign from_low[i] = ser_r;
        end else begin : g_lo_mid
            assign from_low[i] = cur[i-1];
        end
        if (i == TOP) begin : g_hi
            assign from_high[i] = ser_l;
        end else begin : g_hi_mid
            assign from_high[i] = cur[i+1];
        end
    end

    always_comb begin
        unique case (mode)
            M_HOLD: nxt = cur;
            M_SHR:  nxt = from_low;
            M_SHL:  nxt = from_high;
            M_LOAD: nxt = par_d;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/usr_store.sv
module usr_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
    end

    // R6: a clear held over an edge keeps the store empty
    a_r6_clear_wins: assert property (@(posedge clk)
        (!clr_n ##1 !clr_n) |-> (q == '0));
endmodule

// File: rtl/usr4_shift.sv
module usr4_shift
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    usr_mode_e        act;
    logic [WIDTH-1:0] nxt;

    usr_mode_dec u_dec (
        .sel  (mode),
        .mode (act)
    );

    usr_next #(.WIDTH(WIDTH)) u_next (
        .mode  (act),
        .cur   (q),
        .par_d (par_d),
        .ser_r (ser_r),
        .ser_l (ser_l),
        .nxt   (nxt)
    );

    usr_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .q     (q)
    );

    // R1: a load takes the parallel bus
    a_r1_load: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (q == $past(par_d)));

    // R2: right shift brings ser_r into bit 0
    a_r2_shr: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (q == {$past(q[TOP-1:0]), $past(ser_r)}));

    // R3: left shift brings ser_l into the top bit
    a_r3_shl: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (q == {$past(ser_l), $past(q[TOP:1])}));

    // R4: hold keeps the contents
    a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> $stable(q));
endmodule

// File: tb/usr4_shift_tb.sv
`timescale 1ns/100ps
module usr4_shift_tb;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       ser_r = 1'b0;
    logic       ser_l = 1'b0;
    logic [3:0] par_d = 4'b0000;
    logic [3:0] q;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usr4_shift u_dut (
        .clk   (clk),
        .clr_n (clr_n),
        .mode  (mode),
        .ser_r (ser_r),
        .ser_l (ser_l),
        .par_d (par_d),
        .q     (q)
    );

    // entry: {mode, ser_r, ser_l, par_d, expected q after the edge}
    localparam int NV = 18;
    localparam logic [11:0] VEC [0:NV-1] = '{
        {2'b11, 1'b0, 1'b0, 4'b1010, 4'b1010},
        {2'b00, 1'b1, 1'b1, 4'b1111, 4'b1010},
        {2'b01, 1'b1, 1'b0, 4'b0000, 4'b0101},
        {2'b01, 1'b0, 1'b1, 4'b0000, 4'b1010},
        {2'b10, 1'b0, 1'b1, 4'b0000, 4'b1101},
        {2'b10, 1'b1, 1'b0, 4'b0000, 4'b0110},
        {2'b01, 1'b1, 1'b0, 4'b1111, 4'b1101},
        {2'b10, 1'b1, 1'b0, 4'b1111, 4'b0110},
        {2'b11, 1'b0, 1'b0, 4'b1111, 4'b1111},
        {2'b10, 1'b1, 1'b0, 4'b0000, 4'b0111},
        {2'b10, 1'b1, 1'b0, 4'b0000, 4'b0011},
        {2'b01, 1'b0, 1'b1, 4'b0000, 4'b0110},
        {2'b00, 1'b1, 1'b1, 4'b0000, 4'b0110},
        {2'b11, 1'b0, 1'b0, 4'b0001, 4'b0001},
        {2'b01, 1'b1, 1'b0, 4'b0000, 4'b0011},
        {2'b01, 1'b1, 1'b0, 4'b0000, 4'b0111},
        {2'b01, 1'b1, 1'b0, 4'b0000, 4'b1111},
        {2'b01, 1'b0, 1'b1, 4'b0000, 4'b1110}
    };

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: q=%b expected %b", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b11:   return "R1 load";
            2'b01:   return "R2/R8 shift right";
            2'b10:   return "R3/R8 shift left";
            default: return "R4 hold";
        endcase
    endfunction

    initial begin
        logic [3:0] prev;
        #1;
        check(q, 4'b0000, "R5 reset state");
        @(negedge clk);
        clr_n = 1'b1;
        prev = 4'b0000;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {mode, ser_r, ser_l, par_d} = VEC[i][11:4];
            #1;
            check(q, prev, "R7 no change between edges");
            @(posedge clk);
            #1;
            check(q, VEC[i][3:0], tag_of(VEC[i][11:10]));
            prev = VEC[i][3:0];
        end

        // R5: clear between edges takes effect without a clock edge
        @(negedge clk);
        mode = 2'b00;
        #0.5;
        clr_n = 1'b0;
        #0.5;
        check(q, 4'b0000, "R5 async clear");

        // R6: clear held low over an edge in load mode
        mode = 2'b11;
        par_d = 4'b1011;
        @(posedge clk);
        #1;
        check(q, 4'b0000, "R6 clear overrides load");
        mode = 2'b01;
        ser_r = 1'b1;
        @(posedge clk);
        #1;
        check(q, 4'b0000, "R6 clear overrides shift");

        // release clear, then load works again
        @(negedge clk);
        clr_n = 1'b1;
        mode = 2'b11;
        par_d = 4'b1001;
        @(posedge clk);
        #1;
        check(q, 4'b1001, "R1 load after clear");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule